// File: doc/BRIEF.md
# First-Order Digital Delta-Sigma Modulator with Carry-Pipelined Accumulator

This block dithers the division modulus of a fractional-N divider. Each enabled reference clock it adds a fractional word to a running residue, modulo 2^WIDTH. The overflow of that addition is emitted as a one-bit stream. Over a long run, the density of ones in the stream equals the fractional word divided by 2^WIDTH. The divider uses each bit to pick between two adjacent division ratios.

The accumulator is split into narrow adder slices so that wide words still meet timing. Each slice keeps its share of the residue in its own register. A register also sits on the carry path between each pair of slices. The fractional word is skewed by one extra cycle per slice, so that each slice adds the slice of the word that matches its own point in time. The slice residues are then deskewed and appear as one aligned word.

The overflow bit comes straight from a flop, so a later noise-cancelling stage sees no glitches on it. The aligned residue is exposed so that such a stage can be attached later. With the default parameters the latency is 3 enabled cycles. In general the latency is SLICES-1 enabled cycles, where SLICES = WIDTH/SLICE_W.

Top module: `dsm_first_order`

## Requirements
- R1: While `rst` is high at a clock edge, `residue` and `carry_out` become 0 after that edge, whatever `en` and `k_in` are.
- R2: Let A(0)=0 and A(n+1) = (A(n) + k(n)) mod 2^WIDTH, where k(n) is `k_in` at the n-th enabled edge since reset. After n enabled edges, `residue` equals A(n-L), with L = SLICES-1 and A of a negative index taken as 0.
- R3: After n enabled edges, `carry_out` equals the overflow bit (bit WIDTH of the unwrapped sum) produced when A(n-L) was formed. Before such a sum exists, `carry_out` is 0.
- R4: Suppose `k_in` is held at K from reset, and we take 2^WIDTH consecutive enabled cycles after the first L. Then exactly K of those cycles show `carry_out` = 1.
- R5: An edge with `en` low changes neither `residue` nor `carry_out`, whatever `k_in` is.
- R6: With K = 0 held, `carry_out` stays 0. Once 2·SLICES enabled cycles with K = 0 have passed, `carry_out` is 0 whatever came before.
- R7: With K = 2^(WIDTH-1) held, `carry_out` toggles on every enabled edge after pipeline fill.
- R8: If `k_in` changes between enabled edges, each new value counts exactly once, at the edge where it is presented, as stated in R2. Nothing is lost or doubled across the slice skew.
- R9: Elaboration is rejected unless SLICE_W is at least 1 and divides WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low holds all state |
| k_in | input | WIDTH | Fractional word added each enabled cycle |
| carry_out | output | 1 | Registered overflow bit stream |
| residue | output | WIDTH | Aligned accumulator residue, L cycles behind |

## Verification
The hardest case to reach is a carry that ripples through every slice register over several cycles. This happens when the upper residue slices are all ones and a small word produces a low-slice overflow. It gets harder still when `k_in` changes or `en` drops while such a carry is in flight. A sweep over every fractional word of a reduced 8-bit, four-slice build walks the residue through all of its values, including the all-ones patterns. A later run applies random words on random enabled cycles, with gaps, so that in-flight carries meet changing inputs.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
   // Number of enabled cycles between a word entering and its residue/carry appearing.
   function automatic int dsm_latency(input int slices);
      return slices - 1;
   endfunction
endpackage

// File: rtl/dsm_delay.sv
module dsm_delay #(
   parameter int W     = 4,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (DEPTH == 0) begin : g_wire
         assign q = d;
      end else begin : g_regs
         logic [W-1:0] stage [DEPTH];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int j = 0; j < DEPTH; j++) stage[j] <= '0;
            end else if (en) begin
               stage[0] <= d;
               for (int j = 1; j < DEPTH; j++) stage[j] <= stage[j-1];
            end
         end
         assign q = stage[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/dsm_slice.sv
module dsm_slice #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] k,
   input  logic         c_in,
   output logic [W-1:0] res,
   output logic         c_out
);
   logic [W:0] sum;

   always_comb sum = {1'b0, res} + {1'b0, k} + {{W{1'b0}}, c_in};

   always_ff @(posedge clk) begin
      if (rst) begin
         res   <= '0;
         c_out <= 1'b0;
      end else if (en) begin
         res   <= sum[W-1:0];
         c_out <= sum[W];
      end
   end
endmodule

// File: rtl/dsm_first_order.sv
module dsm_first_order
   import dsm_pkg::*;
#(
   parameter int WIDTH   = 16,
   parameter int SLICE_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] k_in,
   output logic             carry_out,
   output logic [WIDTH-1:0] residue
);
   localparam int SLICES = WIDTH / SLICE_W;
   localparam int LAT    = dsm_latency(SLICES);

   // R9: slice width must tile the word exactly
   generate
      if (SLICE_W < 1 || (WIDTH % SLICE_W) != 0 || SLICES < 1) begin : g_bad_cfg
         $error("dsm_first_order: SLICE_W must be >= 1 and divide WIDTH");
      end
   endgenerate

   logic [SLICES:0] carry_chain;
   assign carry_chain[0] = 1'b0;

   generate
      for (genvar i = 0; i < SLICES; i++) begin : g_slice
         logic [SLICE_W-1:0] k_aligned;
         logic [SLICE_W-1:0] res_raw;

         // word skew: slice i adds the word from i enabled cycles ago
         dsm_delay #(.W(SLICE_W), .DEPTH(i)) u_kskew (
            .clk(clk), .rst(rst), .en(en),
            .d(k_in[i*SLICE_W +: SLICE_W]), .q(k_aligned)
         );

         dsm_slice #(.W(SLICE_W)) u_add (
            .clk(clk), .rst(rst), .en(en),
            .k(k_aligned), .c_in(carry_chain[i]),
            .res(res_raw), .c_out(carry_chain[i+1])
         );

         // residue deskew: lower slices wait until the top slice catches up
         dsm_delay #(.W(SLICE_W), .DEPTH(LAT - i)) u_deskew (
            .clk(clk), .rst(rst), .en(en),
            .d(res_raw), .q(residue[i*SLICE_W +: SLICE_W])
         );
      end
   endgenerate

   // top slice carry register drives the output directly
   assign carry_out = carry_chain[SLICES];
endmodule

// File: rtl/dsm_first_order_chk.sv
module dsm_first_order_chk #(
   parameter int WIDTH   = 16,
   parameter int SLICE_W = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             en,
   input logic [WIDTH-1:0] k_in,
   input logic             carry_out,
   input logic [WIDTH-1:0] residue
);
   localparam int SLICES = WIDTH / SLICE_W;
   localparam int SAT    = 2 * SLICES;
   localparam int CW     = $clog2(SAT + 1);
   localparam logic [WIDTH-1:0] HALF = {1'b1, {(WIDTH-1){1'b0}}};

   logic [CW-1:0] zero_run, half_run;

   always_ff @(posedge clk) begin
      if (rst) begin
         zero_run <= '0;
         half_run <= '0;
      end else if (en) begin
         if (k_in != '0) zero_run <= '0;
         else if (zero_run != CW'(SAT)) zero_run <= zero_run + 1'b1;
         if (k_in != HALF) half_run <= '0;
         else if (half_run != CW'(SAT)) half_run <= half_run + 1'b1;
      end
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (residue == '0 && !carry_out));

   assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(residue) && $stable(carry_out)));

   assert_zero_word_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      (zero_run == CW'(SAT)) |-> !carry_out);

   assert_half_word_toggle_R7: assert property (@(posedge clk) disable iff (rst)
      (half_run == CW'(SAT) && en && k_in == HALF) |=> (carry_out != $past(carry_out)));
endmodule

bind dsm_first_order dsm_first_order_chk #(.WIDTH(WIDTH), .SLICE_W(SLICE_W)) u_chk (
   .clk(clk), .rst(rst), .en(en), .k_in(k_in),
   .carry_out(carry_out), .residue(residue)
);

// File: tb/sim_dsm_first_order.sv
module sim_dsm_first_order;
   localparam int W   = 8;
   localparam int SW  = 2;
   localparam int NS  = W / SW;
   localparam int LAT = NS - 1;

   logic clk = 1'b0, rst = 1'b1, en = 1'b0;
   logic [W-1:0] k_in = '0;
   wire carry_out;
   wire [W-1:0] residue;

   always #2.5 clk = ~clk;

   dsm_first_order #(.WIDTH(W), .SLICE_W(SW)) u0 (
      .clk(clk), .rst(rst), .en(en), .k_in(k_in),
      .carry_out(carry_out), .residue(residue)
   );

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   logic [W-1:0] hA [0:LAT];
   logic         hC [0:LAT];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int j = 0; j <= LAT; j++) begin hA[j] = '0; hC[j] = 1'b0; end
   endtask

   task automatic model_step(input logic [W-1:0] k);
      logic [W:0] s;
      s = {1'b0, hA[0]} + {1'b0, k};
      for (int j = LAT; j > 0; j--) begin hA[j] = hA[j-1]; hC[j] = hC[j-1]; end
      hA[0] = s[W-1:0];
      hC[0] = s[W];
   endtask

   // called at a falling edge; returns at the next falling edge after checking R2/R3
   task automatic step(input logic e, input logic [W-1:0] k);
      en = e; k_in = k;
      @(posedge clk);
      if (e) model_step(k);
      @(negedge clk);
      chk(residue == hA[LAT], "R2 residue", int'(residue), int'(hA[LAT]));
      chk(carry_out == hC[LAT], "R3 carry", int'(carry_out), int'(hC[LAT]));
   endtask

   task automatic do_reset();
      rst = 1'b1; en = 1'b1; k_in = 8'h5A;
      @(posedge clk); @(posedge clk); @(negedge clk);
      model_clear();
      chk(residue == '0, "R1 residue after reset", int'(residue), 0);
      chk(carry_out == 1'b0, "R1 carry after reset", int'(carry_out), 0);
      rst = 1'b0;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();

      // exhaustive sweep over every fractional word: R2, R3, R4, R6, R7
      for (int kv = 0; kv < (1 << W); kv++) begin
         int  ones;
         bit  zero_ok, alt_ok;
         logic prev;
         do_reset();
         ones = 0; zero_ok = 1; alt_ok = 1; prev = 1'b0;
         for (int n = 1; n <= LAT + (1 << W); n++) begin
            step(1'b1, kv[W-1:0]);
            if (n > LAT) begin
               ones += int'(carry_out);
               if (carry_out) zero_ok = 0;
               if (n > LAT + 1 && carry_out == prev) alt_ok = 0;
               prev = carry_out;
            end
         end
         chk(ones == kv, "R4 ones per full window", ones, kv);
         if (kv == 0) chk(zero_ok, "R6 zero word gives no ones", int'(zero_ok), 1);
         if (kv == (1 << (W-1))) chk(alt_ok, "R7 half word alternates", int'(alt_ok), 1);
      end

      // R5: enable low holds state while k_in wanders
      do_reset();
      for (int n = 0; n < 7; n++) step(1'b1, 8'h37);
      begin
         logic [W-1:0] held_r;
         logic         held_c;
         held_r = residue; held_c = carry_out;
         for (int n = 0; n < 6; n++) begin
            step(1'b0, W'($urandom));
            chk(residue == held_r, "R5 residue held", int'(residue), int'(held_r));
            chk(carry_out == held_c, "R5 carry held", int'(carry_out), int'(held_c));
         end
      end
      for (int n = 0; n < 5; n++) step(1'b1, 8'h37);

      // R8: word changes with enable gaps, carries in flight
      for (int n = 0; n < 800; n++) step($urandom_range(0, 3) != 0, W'($urandom));

      // R8: all-ones residue followed by small words (long ripple)
      do_reset();
      for (int n = 0; n < 10; n++) step(1'b1, (n == 0) ? 8'hFF : 8'h00);
      for (int n = 0; n < 12; n++) step(1'b1, 8'h01);

      // R1: reset in the middle of activity
      for (int n = 0; n < 9; n++) step(1'b1, 8'hC3);
      do_reset();

      done = 1;
      summary();
      $finish;
   end
endmodule